// File: doc/BRIEF.md
# DDR Mode Register Capture Unit

This unit sits on the device side of a DDR SDRAM command bus. On each rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable pins, the bank-address pins and the address pins. It recognises a mode-register-set command aimed at either the base mode register or the extended register. For a base-register write it decodes burst length, burst ordering, read latency and the DLL-reset request, and presents them to the rest of the device logic.

The unit checks the programming rules before it accepts a write. All banks must be idle. Clock enable must be high on the command edge and on the edge before it. No other command may arrive during the two-cycle completion window. The extended register must already have been written. No reserved code or reserved bit may be used, and the test bit must be clear. A write that breaks any of these rules is dropped and the previous settings are kept. Each broken rule sets its own flag in a sticky error vector. Read latency is reported in half-cycle units, so the half-cycle settings need no separate fraction bit.

Top module: `ddr_modereg_capture`

## Requirements
- R1: A mode-register-set command is sampled on a rising edge when chip select, row strobe, column strobe and write enable are all low. Bank address bit 0 low selects the base register and high selects the extended register. Any other pin combination leaves every configuration output unchanged.
- R2: On an accepted base write, address bits 2:0 set `burst_len_o`: 001 gives 2, 010 gives 4, 011 gives 8.
- R3: On an accepted base write, address bit 3 sets `burst_ilv_o`: 0 gives sequential order (output 0), 1 gives interleaved order (output 1).
- R4: On an accepted base write, address bits 6:4 set `rd_lat_half_o` in half cycles: 101 gives 3, 010 gives 4, 110 gives 5, 011 gives 6.
- R5: A base write that arrives before any accepted extended write is rejected and sets `err_o[6]`. `cfg_valid_o` stays 0.
- R6: An accepted write (base or extended) holds `busy_o` high for the two cycles after its sampling edge. Any command other than NOP that is sampled while `busy_o` is high is rejected and sets `err_o[5]`.
- R7: A write is rejected if `banks_idle_i` is low on its edge (sets `err_o[4]`). It is also rejected if `cke_i` is low on its edge or on the edge before (sets `err_o[7]`).
- R8: A base write is rejected with the previous fields kept in each of these cases: a reserved burst code (sets `err_o[0]`), a reserved latency code (sets `err_o[1]`), address bit 7 set (sets `err_o[2]`), or a nonzero value in address bits 12:9 or bank address bit 1 (sets `err_o[3]`).
- R9: Error bits stay set until reset. Several faults in the same command all set their bits.
- R10: An accepted base write with address bit 8 set drives `dll_rst_o` high for exactly the one cycle after its sampling edge.
- R11: `cfg_valid_o` rises two edges after the sampling edge of the first accepted base write and stays high until reset.
- R12: After reset every output is 0. Reset is asserted asynchronously, and the first edge that acts on commands is the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 13 | Address pins |
| banks_idle_i | input | 1 | High when all banks are precharged and idle |
| busy_o | output | 1 | Write completion window active |
| cfg_valid_o | output | 1 | Base register has been validly programmed |
| burst_len_o | output | 4 | Burst length in beats |
| burst_ilv_o | output | 1 | 1 = interleaved burst order |
| rd_lat_half_o | output | 3 | Read latency in half cycles |
| dll_rst_o | output | 1 | One-cycle DLL reset pulse |
| err_o | output | 8 | Sticky fault flags |

## Verification
The assertions assume the command pins and `banks_idle_i` are stable around each rising edge. They also assume `banks_idle_i` truthfully reports the bank state, because the unit cannot check it. The bench changes every input only on falling edges and drives NOPs during the reset-release window. It issues commands only with `cke_i` held high, except in the case that deliberately drops `cke_i` for one cycle. Its reference model copies the two-edge reset release, so the comparison on each cycle starts from the same state as the design.

// File: rtl/ddr_mr_pkg.sv
package ddr_mr_pkg;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_OTHER,
    CMD_MR_BASE,
    CMD_MR_EXT
  } mr_cmd_e;

  typedef struct packed {
    logic [3:0] blen;
    logic       ilv;
    logic [2:0] lat_half;
  } mr_cfg_t;

  localparam int ERR_W     = 8;
  localparam int E_BL      = 0;
  localparam int E_LAT     = 1;
  localparam int E_TEST    = 2;
  localparam int E_RSV     = 3;
  localparam int E_IDLE    = 4;
  localparam int E_BUSY    = 5;
  localparam int E_ORDER   = 6;
  localparam int E_CKE     = 7;

endpackage

// File: rtl/ddr_mr_cmd_decode.sv
module ddr_mr_cmd_decode
  import ddr_mr_pkg::*;
(
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  input  logic    sel_ext,
  output mr_cmd_e cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      if (!ras_n && !cas_n && !we_n) begin
        cmd = sel_ext ? CMD_MR_EXT : CMD_MR_BASE;
      end else if (!(ras_n && cas_n && we_n)) begin
        cmd = CMD_OTHER;
      end
    end
  end

endmodule

// File: rtl/ddr_mr_field_decode.sv
module ddr_mr_field_decode
  import ddr_mr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-2:0]   ba_hi,
  output mr_cfg_t           cfg,
  output logic              bl_bad,
  output logic              lat_bad,
  output logic              test_bad,
  output logic              rsv_bad,
  output logic              dll_req
);

  localparam int FIRST_RSV = 9;

  always_comb begin
    bl_bad = 1'b0;
    unique case (addr[2:0])
      3'b001:  cfg.blen = 4'd2;
      3'b010:  cfg.blen = 4'd4;
      3'b011:  cfg.blen = 4'd8;
      default: begin
        cfg.blen = 4'd0;
        bl_bad   = 1'b1;
      end
    endcase
  end

  always_comb begin
    lat_bad = 1'b0;
    unique case (addr[6:4])
      3'b101:  cfg.lat_half = 3'd3;
      3'b010:  cfg.lat_half = 3'd4;
      3'b110:  cfg.lat_half = 3'd5;
      3'b011:  cfg.lat_half = 3'd6;
      default: begin
        cfg.lat_half = 3'd0;
        lat_bad      = 1'b1;
      end
    endcase
  end

  assign cfg.ilv  = addr[3];
  assign test_bad = addr[7];
  assign dll_req  = addr[8];
  assign rsv_bad  = (|addr[ADDR_W-1:FIRST_RSV]) | (|ba_hi);

endmodule

// File: rtl/ddr_mr_busy_timer.sv
module ddr_mr_busy_timer #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);

  localparam int CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = CNT_W'(CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1));

  p_start_then_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  p_no_start_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/ddr_modereg_capture.sv
module ddr_modereg_capture
  import ddr_mr_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_i,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              banks_idle_i,
  output logic              busy_o,
  output logic              cfg_valid_o,
  output logic [3:0]        burst_len_o,
  output logic              burst_ilv_o,
  output logic [2:0]        rd_lat_half_o,
  output logic              dll_rst_o,
  output logic [ERR_W-1:0]  err_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign rst_ni = rst_s2_q;

  // decode
  mr_cmd_e cmd;
  mr_cfg_t dec_cfg;
  logic    bl_bad, lat_bad, test_bad, rsv_bad, dll_req;
  logic    busy, win_last;

  ddr_mr_cmd_decode u_cmd (
    .cs_n    (cs_n_i),
    .ras_n   (ras_n_i),
    .cas_n   (cas_n_i),
    .we_n    (we_n_i),
    .sel_ext (ba_i[0]),
    .cmd     (cmd)
  );

  ddr_mr_field_decode #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_fields (
    .addr     (addr_i),
    .ba_hi    (ba_i[BA_W-1:1]),
    .cfg      (dec_cfg),
    .bl_bad   (bl_bad),
    .lat_bad  (lat_bad),
    .test_bad (test_bad),
    .rsv_bad  (rsv_bad),
    .dll_req  (dll_req)
  );

  // state
  mr_cfg_t          cfg_q;
  logic             ext_done_q, ext_done_d;
  logic             base_pend_q, base_pend_d;
  logic             valid_q, valid_d;
  logic             dll_q, dll_d;
  logic             cke_q;
  logic [ERR_W-1:0] err_q, err_d, fault;
  logic             is_cmd, is_mr, is_base, accept, cfg_we;

  always_comb begin
    is_cmd  = (cmd != CMD_NONE);
    is_base = (cmd == CMD_MR_BASE);
    is_mr   = is_base || (cmd == CMD_MR_EXT);

    fault          = '0;
    fault[E_BUSY]  = is_cmd & busy;
    fault[E_IDLE]  = is_mr & ~banks_idle_i;
    fault[E_CKE]   = is_mr & ~(cke_i & cke_q);
    fault[E_BL]    = is_base & bl_bad;
    fault[E_LAT]   = is_base & lat_bad;
    fault[E_TEST]  = is_base & test_bad;
    fault[E_RSV]   = is_base & rsv_bad;
    fault[E_ORDER] = is_base & ~ext_done_q;

    accept      = is_mr & ~(|fault);
    cfg_we      = accept & is_base;
    err_d       = err_q | fault;
    ext_done_d  = ext_done_q | (accept & ~is_base);
    base_pend_d = accept ? is_base : base_pend_q;
    valid_d     = valid_q | (win_last & base_pend_q);
    dll_d       = cfg_we & dll_req;
  end

  ddr_mr_busy_timer #(
    .CYC (BUSY_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_ni),
    .start (accept),
    .busy  (busy),
    .last  (win_last)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      ext_done_q  <= 1'b0;
      base_pend_q <= 1'b0;
      valid_q     <= 1'b0;
      dll_q       <= 1'b0;
      cke_q       <= 1'b0;
      err_q       <= '0;
    end else begin
      if (cfg_we) begin
        cfg_q <= dec_cfg;
      end
      ext_done_q  <= ext_done_d;
      base_pend_q <= base_pend_d;
      valid_q     <= valid_d;
      dll_q       <= dll_d;
      cke_q       <= cke_i;
      err_q       <= err_d;
    end
  end

  assign busy_o        = busy;
  assign cfg_valid_o   = valid_q;
  assign burst_len_o   = cfg_q.blen;
  assign burst_ilv_o   = cfg_q.ilv;
  assign rd_lat_half_o = cfg_q.lat_half;
  assign dll_rst_o     = dll_q;
  assign err_o         = err_q;

  p_reject_keeps_cfg_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_mr && !accept) |=> $stable(cfg_q));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    ((err_q & $past(err_q)) == $past(err_q)));

  p_valid_needs_ext_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_q |-> ext_done_q);

  p_dll_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    dll_q |=> !dll_q);

  p_valid_blen_legal_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_q |-> (cfg_q.blen == 4'd2 || cfg_q.blen == 4'd4 || cfg_q.blen == 4'd8));

  p_valid_lat_legal_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_q |-> (cfg_q.lat_half >= 3'd3 && cfg_q.lat_half <= 3'd6));

endmodule

// File: tb/tb_ddr_modereg_capture.sv
`timescale 1ns/1ps
module tb_ddr_modereg_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        idle = 1'b1;
  logic        busy, valid, ilv, dll;
  logic [3:0]  blen;
  logic [2:0]  lat;
  logic [7:0]  err;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  ddr_modereg_capture dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cke_i         (cke),
    .cs_n_i        (cs_n),
    .ras_n_i       (ras_n),
    .cas_n_i       (cas_n),
    .we_n_i        (we_n),
    .ba_i          (ba),
    .addr_i        (addr),
    .banks_idle_i  (idle),
    .busy_o        (busy),
    .cfg_valid_o   (valid),
    .burst_len_o   (blen),
    .burst_ilv_o   (ilv),
    .rd_lat_half_o (lat),
    .dll_rst_o     (dll),
    .err_o         (err)
  );

  // behavioural reference model
  int m_bl, m_lat, m_ilv, m_busy, m_valid, m_dll, m_err, m_ext, m_pend, m_ckeq, m_live;

  function automatic int ref_bl(input logic [2:0] c);
    if (c == 3'd1) return 2;
    if (c == 3'd2) return 4;
    if (c == 3'd3) return 8;
    return -1;
  endfunction

  function automatic int ref_lat(input logic [2:0] c);
    if (c == 3'd5) return 3;
    if (c == 3'd2) return 4;
    if (c == 3'd6) return 5;
    if (c == 3'd3) return 6;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bl = 0; m_lat = 0; m_ilv = 0; m_busy = 0; m_valid = 0; m_dll = 0;
      m_err = 0; m_ext = 0; m_pend = 0; m_ckeq = 0; m_live = 0;
    end else if (m_live < 2) begin
      m_live++;
    end else begin
      bit anycmd, mr, base, acc;
      int e;
      anycmd = !cs_n && !(ras_n && cas_n && we_n);
      mr     = !cs_n && !ras_n && !cas_n && !we_n;
      base   = mr && !ba[0];
      e = 0;
      if (anycmd && m_busy > 0) e |= 32;
      if (mr && !idle) e |= 16;
      if (mr && !(cke && m_ckeq != 0)) e |= 128;
      if (base) begin
        if (ref_bl(addr[2:0]) < 0) e |= 1;
        if (ref_lat(addr[6:4]) < 0) e |= 2;
        if (addr[7]) e |= 4;
        if (addr[12:9] != 0 || ba[1]) e |= 8;
        if (m_ext == 0) e |= 64;
      end
      acc = mr && (e == 0);
      m_err |= e;
      m_dll = (acc && base && addr[8]) ? 1 : 0;
      if (m_busy == 1 && m_pend != 0) m_valid = 1;
      if (acc) begin
        m_busy = 2;
        m_pend = base ? 1 : 0;
        if (base) begin
          m_bl = ref_bl(addr[2:0]); m_lat = ref_lat(addr[6:4]); m_ilv = addr[3];
        end else begin
          m_ext = 1;
        end
      end else if (m_busy > 0) begin
        m_busy--;
      end
      m_ckeq = cke;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R2 burst_len vs model", blen, m_bl);
      chk("R3 burst order vs model", ilv, m_ilv);
      chk("R4 read latency vs model", lat, m_lat);
      chk("R6 busy vs model", busy, m_busy > 0);
      chk("R11 cfg_valid vs model", valid, m_valid);
      chk("R10 dll pulse vs model", dll, m_dll);
      chk("R9 err vs model", err, m_err);
    end
  end

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] pins, input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = pins; ba = b; addr = a;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b1111; ba = '0; addr = '0;
  endtask

  task automatic mrs(input logic [1:0] b, input logic [12:0] a);
    issue(4'b0000, b, a);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset valid", valid, 0);
    chk("R12 reset err", err, 0);
    chk("R12 reset burst_len", blen, 0);
    chk("R12 reset latency", lat, 0);
    chk("R12 reset dll", dll, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cyc(4);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    cmp_en = 1'b1;
    do_reset();

    // R5: base before extended
    mrs(2'b00, 13'h022);
    chk("R5 order error bit", err[6], 1);
    chk("R5 burst_len unchanged", blen, 0);
    idle_cyc(3);
    chk("R5 valid stays low", valid, 0);

    do_reset();
    // extended then base
    mrs(2'b01, 13'h000);
    chk("R6 busy after ext write", busy, 1);
    idle_cyc(1);
    chk("R6 busy second cycle", busy, 1);
    idle_cyc(1);
    chk("R6 busy dropped", busy, 0);
    mrs(2'b00, 13'h022);
    chk("R2 burst 4", blen, 4);
    chk("R3 sequential", ilv, 0);
    chk("R4 latency 2 cycles", lat, 4);
    idle_cyc(1);
    chk("R11 valid not yet", valid, 0);
    idle_cyc(1);
    chk("R11 valid risen", valid, 1);

    mrs(2'b00, 13'h16B);
    chk("R10 dll pulse", dll, 1);
    chk("R2 burst 8", blen, 8);
    chk("R3 interleaved", ilv, 1);
    chk("R4 latency 2.5", lat, 5);
    idle_cyc(1);
    chk("R10 dll pulse ends", dll, 0);
    idle_cyc(2);
    mrs(2'b00, 13'h051);
    chk("R2 burst 2", blen, 2);
    chk("R4 latency 1.5", lat, 3);
    idle_cyc(3);
    mrs(2'b00, 13'h032);
    chk("R4 latency 3", lat, 6);
    idle_cyc(3);

    // R6: command inside window
    mrs(2'b00, 13'h022);
    mrs(2'b00, 13'h013);
    chk("R6 busy error bit", err[5], 1);
    chk("R6 burst kept", blen, 4);
    idle_cyc(3);

    // R8: reserved codes and bits
    mrs(2'b00, 13'h020);
    chk("R8 burst code error", err[0], 1);
    chk("R8 burst kept", blen, 4);
    idle_cyc(2);
    mrs(2'b00, 13'h002);
    chk("R8 latency code error", err[1], 1);
    chk("R8 latency kept", lat, 4);
    idle_cyc(2);
    mrs(2'b00, 13'h0A2);
    chk("R8 test bit error", err[2], 1);
    idle_cyc(2);
    mrs(2'b00, 13'h422);
    chk("R8 reserved bit error", err[3], 1);
    idle_cyc(2);
    mrs(2'b10, 13'h022);
    idle_cyc(2);

    // R7: banks not idle
    idle = 1'b0;
    mrs(2'b00, 13'h032);
    idle = 1'b1;
    chk("R7 not idle error", err[4], 1);
    chk("R7 latency kept", lat, 4);
    idle_cyc(2);

    // R7: clock enable low on the previous edge
    cke = 1'b0;
    idle_cyc(1);
    cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = 4'b0000; addr = 13'h032;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b1111; addr = '0;
    chk("R7 cke error", err[7], 1);
    chk("R7 latency kept after cke", lat, 4);

    // R9: everything but the order bit stays set
    idle_cyc(10);
    chk("R9 sticky errors", err, 8'hBF);

    // R1: other commands are not writes
    do_reset();
    mrs(2'b01, 13'h000);
    idle_cyc(3);
    issue(4'b0011, 2'b00, 13'h022);
    chk("R1 activate ignored burst", blen, 0);
    chk("R1 activate no busy", busy, 0);
    chk("R1 activate no error", err, 0);
    issue(4'b1000, 2'b00, 13'h022);
    chk("R1 deselected ignored", blen, 0);
    chk("R1 deselected no error", err, 0);
    mrs(2'b00, 13'h033);
    chk("R1 real write taken", blen, 8);
    idle_cyc(4);

    finish_run();
  end

endmodule